// File: doc/BRIEF.md
# Coprocessor Load/Store and Register-Field Access Unit

This unit carries out the four memory-side instructions of a small coprocessor. These are the word load, the word store, the register-field read and the register-field write. The sequencer hands it one instruction at a time over a valid/ready request port. The instruction carries the opcode, a base value, a signed byte offset, the store source, a register-space address, a bit range, an 8-bit immediate, the destination index and the current program counter. The unit then runs the bus transactions that the instruction needs. Loads and field reads return a 16-bit result over a valid/ready response port. Every finished instruction raises a single-cycle completion strobe.

Memory operands are 32-bit words addressed in words. The unit adds the byte offset to the base and drops the two lowest bits. A store packs the source half-word below a copy of the program counter shifted left by five. A field write is a read-modify-write: it reads the register word, merges the immediate under a mask built from the bit range, and writes the word back. The shared bus also serves a host that always wins. The unit holds each request steady until the arbiter grants it.

The request port accepts a new instruction only while the unit is idle. The sequencer must hold the request fields stable while `req_valid` is high and `req_ready` is low. The response port holds `rsp_data` and `rsp_dst` stable while `rsp_valid` is high and `rsp_ready` is low. The unit takes no new instruction until the response is consumed.

Top module: `cop_mem_unit`

## Requirements
- R1: The memory word address is (base + sign-extended 10-bit byte offset) modulo 2^16, shifted right by two, keeping 11 bits. A byte offset that is not a multiple of four is therefore truncated.
- R2: A store (opcode 1) issues exactly one memory write with `bus_space`=0 and no read. The written word has the 16-bit source in bits 15:0 and (PC << 5), cut to 16 bits, in bits 31:16.
- R3: A load (opcode 0) issues one memory read with `bus_space`=0. It then responds with bits 15:0 of the word read and with `rsp_dst` equal to the request's `req_dst`.
- R4: A field read (opcode 2) issues one register-space read (`bus_space`=1) at `req_raddr`. It responds with bits [hi:lo] of that word, right-aligned and zero-filled, keeping only the lowest 16 bits. `rsp_dst` is 0.
- R5: A field write (opcode 3) reads the register word and then writes to the same address. The written value replaces bits [hi:lo] with the zero-extended 8-bit immediate, and field bits beyond the eighth become 0. All other bits are unchanged.
- R6: A bus request keeps `bus_addr`, `bus_we`, `bus_wdata` and `bus_space` stable until a cycle with `bus_gnt`=1, and the access happens in that cycle. Read data is taken from `bus_rdata` one cycle after the grant. When no request is raised, all bus outputs are 0.
- R7: `req_ready` is high only while the unit is idle, and an instruction is taken in a cycle with `req_valid` and `req_ready` both high.
- R8: `rsp_valid` and its data stay stable until a cycle with `rsp_ready` high. `rsp_data` and `rsp_dst` read 0 while `rsp_valid` is low.
- R9: `done` is a one-cycle pulse. It fires in the granted write cycle of a store or field write, or in the response handshake cycle of a load or field read.
- R10: During and after reset the unit is idle: `req_ready`=1, and no bus request, response or `done`.
- R11: With hi < lo the field is empty. A field read then returns 0, and a field write writes back the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction request valid |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 load, 1 store, 2 field read, 3 field write |
| req_base | input | 16 | Base byte address from the base register |
| req_off | input | 10 | Signed byte offset |
| req_src | input | 16 | Store source value |
| req_raddr | input | 8 | Register-space word address |
| req_hi | input | 5 | Upper bit of the field |
| req_lo | input | 5 | Lower bit of the field |
| req_imm | input | 8 | Field write immediate |
| req_pc | input | 11 | Current program counter in words |
| req_dst | input | 2 | Destination register of a load |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_space | output | 1 | 0 memory, 1 register space |
| bus_addr | output | 11 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a granted read |
| bus_gnt | input | 1 | Grant, low while the host holds the bus |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Register file takes the result |
| rsp_data | output | 16 | Result value |
| rsp_dst | output | 2 | Destination register index |
| done | output | 1 | Instruction completion strobe |

## Verification
A store shows its write on the bus in the cycle after acceptance. Every other instruction raises its read in that cycle. Data read under a grant in cycle G is captured at the end of G+1. The response is valid from G+2, and a field write raises its write-back request in G+2. The reference model in the bench steps through those phases with the same grant and ready inputs the DUT sees. It predicts every output for the current cycle and compares them one nanosecond after the falling edge, once the inputs for that cycle have settled. The grant is held low in bursts, and response back-pressure is random, so every wait case comes up.

// File: rtl/cop_mem_pkg.sv
package cop_mem_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RREAD  = 2'd2,
    OP_RWRITE = 2'd3
  } cop_op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD   = 3'd1,
    PH_CAP  = 3'd2,
    PH_RSP  = 3'd3,
    PH_WR   = 3'd4
  } cop_phase_e;

  function automatic logic op_is_reg(cop_op_e op);
    return (op == OP_RREAD) || (op == OP_RWRITE);
  endfunction

endpackage

// File: rtl/cop_addr_gen.sv
module cop_addr_gen #(
  parameter int BASEW = 16,
  parameter int OFFW  = 10,
  parameter int MAW   = 11
) (
  input  logic [BASEW-1:0] base,
  input  logic [OFFW-1:0]  off,
  output logic [MAW-1:0]   word_addr
);
  localparam int EXTW = BASEW - OFFW;

  logic [BASEW-1:0] off_ext;
  logic [BASEW-1:0] byte_addr;

  assign off_ext   = {{EXTW{off[OFFW-1]}}, off};
  assign byte_addr = base + off_ext;
  assign word_addr = MAW'(byte_addr >> 2);
endmodule

// File: rtl/cop_store_fmt.sv
module cop_store_fmt #(
  parameter int HW       = 16,
  parameter int PCW      = 11,
  parameter int PC_SHIFT = 5,
  parameter int DW       = 2 * HW
) (
  input  logic [HW-1:0]  src,
  input  logic [PCW-1:0] pc,
  output logic [DW-1:0]  word
);
  localparam int PCSW = PCW + PC_SHIFT;

  logic [PCSW-1:0] pc_shifted;
  logic [HW-1:0]   upper;

  assign pc_shifted = {pc, {PC_SHIFT{1'b0}}};
  assign upper      = HW'(pc_shifted);
  assign word       = {upper, src};
endmodule

// File: rtl/cop_field_unit.sv
module cop_field_unit #(
  parameter int DW   = 32,
  parameter int HW   = 16,
  parameter int IMMW = 8,
  parameter int BW   = $clog2(DW)
) (
  input  logic [DW-1:0]   old_word,
  input  logic [BW-1:0]   hi,
  input  logic [BW-1:0]   lo,
  input  logic [IMMW-1:0] imm,
  output logic [HW-1:0]   extract,
  output logic [DW-1:0]   merged
);
  logic [DW-1:0] mask;
  logic [DW-1:0] imm_placed;
  logic [DW-1:0] picked;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (lo <= BW'(i)) && (BW'(i) <= hi);
  end

  assign imm_placed = DW'(imm) << lo;
  assign picked     = (old_word & mask) >> lo;
  assign extract    = HW'(picked);
  assign merged     = (old_word & ~mask) | (imm_placed & mask);
endmodule

// File: rtl/cop_access_fsm.sv
module cop_access_fsm
  import cop_mem_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  cop_op_e req_op,
  input  cop_op_e held_op,
  input  logic    bus_gnt,
  input  logic    rsp_ready,
  output logic    req_ready,
  output logic    accept,
  output logic    bus_req,
  output logic    bus_we,
  output logic    cap_en,
  output logic    rsp_valid,
  output logic    done
);
  cop_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (req_valid) ph_d = (req_op == OP_STORE) ? PH_WR : PH_RD;
      PH_RD:   if (bus_gnt) ph_d = PH_CAP;
      PH_CAP:  ph_d = (held_op == OP_RWRITE) ? PH_WR : PH_RSP;
      PH_RSP:  if (rsp_ready) ph_d = PH_IDLE;
      PH_WR:   if (bus_gnt) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign bus_req   = (ph_q == PH_RD) || (ph_q == PH_WR);
  assign bus_we    = (ph_q == PH_WR);
  assign cap_en    = (ph_q == PH_CAP);
  assign rsp_valid = (ph_q == PH_RSP);
  assign done      = ((ph_q == PH_RSP) && rsp_ready) || ((ph_q == PH_WR) && bus_gnt);
endmodule

// File: rtl/cop_mem_unit.sv
module cop_mem_unit
  import cop_mem_pkg::*;
#(
  parameter int DW       = 32,
  parameter int HW       = 16,
  parameter int BASEW    = 16,
  parameter int OFFW     = 10,
  parameter int MAW      = 11,
  parameter int RAW      = 8,
  parameter int PCW      = 11,
  parameter int PC_SHIFT = 5,
  parameter int IMMW     = 8,
  parameter int REGW     = 2,
  parameter int BW       = $clog2(DW),
  parameter int AW       = (MAW > RAW) ? MAW : RAW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [BASEW-1:0] req_base,
  input  logic [OFFW-1:0]  req_off,
  input  logic [HW-1:0]    req_src,
  input  logic [RAW-1:0]   req_raddr,
  input  logic [BW-1:0]    req_hi,
  input  logic [BW-1:0]    req_lo,
  input  logic [IMMW-1:0]  req_imm,
  input  logic [PCW-1:0]   req_pc,
  input  logic [REGW-1:0]  req_dst,
  output logic             bus_req,
  output logic             bus_we,
  output logic             bus_space,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_gnt,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [HW-1:0]    rsp_data,
  output logic [REGW-1:0]  rsp_dst,
  output logic             done
);
  cop_op_e in_op;
  cop_op_e op_q;

  logic [MAW-1:0]  mem_word_addr;
  logic [DW-1:0]   store_word;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   store_q;
  logic [DW-1:0]   rd_q;
  logic [BW-1:0]   hi_q, lo_q;
  logic [IMMW-1:0] imm_q;
  logic [REGW-1:0] dst_q;
  logic [HW-1:0]   field_val;
  logic [DW-1:0]   merged_word;
  logic            accept, cap_en;
  logic            req_int, we_int, rvalid_int;

  assign in_op = cop_op_e'(req_op);

  cop_addr_gen #(.BASEW(BASEW), .OFFW(OFFW), .MAW(MAW)) u_addr (
    .base(req_base), .off(req_off), .word_addr(mem_word_addr)
  );

  cop_store_fmt #(.HW(HW), .PCW(PCW), .PC_SHIFT(PC_SHIFT), .DW(DW)) u_fmt (
    .src(req_src), .pc(req_pc), .word(store_word)
  );

  cop_field_unit #(.DW(DW), .HW(HW), .IMMW(IMMW), .BW(BW)) u_field (
    .old_word(rd_q), .hi(hi_q), .lo(lo_q), .imm(imm_q),
    .extract(field_val), .merged(merged_word)
  );

  cop_access_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(in_op), .held_op(op_q),
    .bus_gnt(bus_gnt), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .accept(accept),
    .bus_req(req_int), .bus_we(we_int), .cap_en(cap_en),
    .rsp_valid(rvalid_int), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      store_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      imm_q   <= '0;
      dst_q   <= '0;
    end else if (accept) begin
      op_q    <= in_op;
      addr_q  <= op_is_reg(in_op) ? AW'(req_raddr) : AW'(mem_word_addr);
      store_q <= store_word;
      hi_q    <= req_hi;
      lo_q    <= req_lo;
      imm_q   <= req_imm;
      dst_q   <= (in_op == OP_LOAD) ? req_dst : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= bus_rdata;
  end

  assign bus_req   = req_int;
  assign bus_we    = we_int;
  assign bus_space = req_int && op_is_reg(op_q);
  assign bus_addr  = req_int ? addr_q : '0;

  always_comb begin
    bus_wdata = '0;
    if (we_int) bus_wdata = (op_q == OP_STORE) ? store_q : merged_word;
  end

  assign rsp_valid = rvalid_int;

  always_comb begin
    rsp_data = '0;
    rsp_dst  = '0;
    if (rvalid_int) begin
      rsp_data = (op_q == OP_LOAD) ? HW'(rd_q) : field_val;
      rsp_dst  = dst_q;
    end
  end
endmodule

// File: rtl/cop_mem_unit_chk.sv
module cop_mem_unit_chk #(
  parameter int AW       = 11,
  parameter int DW       = 32,
  parameter int HW       = 16,
  parameter int REGW     = 2,
  parameter int PC_SHIFT = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            bus_req,
  input logic            bus_we,
  input logic            bus_space,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_gnt,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [HW-1:0]   rsp_data,
  input logic [REGW-1:0] rsp_dst,
  input logic            done
);
  // R6: a stalled request keeps its whole bus picture
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_wdata) && $stable(bus_space));

  // R6: quiet bus outside an access
  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !bus_we && !bus_space && bus_addr == '0 && bus_wdata == '0);

  // R8: response held under back-pressure
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_dst));

  // R7: idle means nothing else is in flight
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req && !rsp_valid);

  // R9: completion is a single-cycle pulse tied to a finishing handshake
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_req && bus_we && bus_gnt) || (rsp_valid && rsp_ready));

  // R2: the PC copy in a store word leaves its low shift bits clear
  p_store_pc_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && !bus_space |-> bus_wdata[HW +: PC_SHIFT] == '0);

  // R10: nothing active while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r10: assert (req_ready && !bus_req && !rsp_valid && !done);
    end
  end
endmodule

bind cop_mem_unit cop_mem_unit_chk #(
  .AW(AW), .DW(DW), .HW(HW), .REGW(REGW), .PC_SHIFT(PC_SHIFT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_dst(rsp_dst), .done(done)
);

// File: tb/cop_mem_unit_tb_top.sv
module cop_mem_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int NOPS  = 400;
  localparam int MAXC  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [15:0] req_base;
  logic [9:0]  req_off;
  logic [15:0] req_src;
  logic [7:0]  req_raddr;
  logic [4:0]  req_hi, req_lo;
  logic [7:0]  req_imm;
  logic [10:0] req_pc;
  logic [1:0]  req_dst;
  logic        bus_req, bus_we, bus_space, bus_gnt;
  logic [10:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rsp_valid, rsp_ready, done;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_dst;

  cop_mem_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_base(req_base), .req_off(req_off), .req_src(req_src),
    .req_raddr(req_raddr), .req_hi(req_hi), .req_lo(req_lo),
    .req_imm(req_imm), .req_pc(req_pc), .req_dst(req_dst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_gnt(bus_gnt), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_dst(rsp_dst), .done(done)
  );

  logic [31:0] mem  [0:2047];
  logic [31:0] regs [0:255];

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  int          ph = 0;
  int          m_op = 0;
  logic [31:0] m_addr, m_wdata, m_word;
  logic [15:0] m_rsp;
  logic [1:0]  m_dst;
  int          m_hi, m_lo;
  logic [7:0]  m_imm;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(logic [15:0] b, logic [9:0] o);
    int s = int'(b) + int'($signed(o));
    s = s & 16'hFFFF;
    return 32'((s / 4) % 2048);
  endfunction

  function automatic logic [15:0] field_get(logic [31:0] w, int hi, int lo);
    logic [15:0] r = '0;
    for (int i = lo; i <= hi; i++) if (i - lo < 16) r[i-lo] = w[i];
    return r;
  endfunction

  function automatic logic [31:0] field_put(logic [31:0] w, int hi, int lo, logic [7:0] v);
    logic [31:0] r = w;
    for (int i = lo; i <= hi; i++) r[i] = (i - lo < 8) ? v[i-lo] : 1'b0;
    return r;
  endfunction

  task automatic set_req(int op, int base, int off, int src, int ra, int hi, int lo,
                         int imm, int pc, int dst);
    req_op = 2'(op); req_base = 16'(base); req_off = 10'(off); req_src = 16'(src);
    req_raddr = 8'(ra); req_hi = 5'(hi); req_lo = 5'(lo); req_imm = 8'(imm);
    req_pc = 11'(pc); req_dst = 2'(dst);
  endtask

  task automatic gen_op(int k);
    case (k)
      0: set_req(1, 16'h0104, -4, 16'hBEEF, 0, 0, 0, 0, 11'h7FF, 0); // R2 store, R1 negative offset
      1: set_req(0, 16'h00FD, 3, 0, 0, 0, 0, 0, 0, 2);             // R1 truncation, R3 load back
      2: set_req(3, 0, 0, 0, 5, 7, 4, 8'hA5, 0, 0);                 // R5 narrow field
      3: set_req(2, 0, 0, 0, 5, 7, 4, 0, 0, 3);                     // R4 read back
      4: set_req(3, 0, 0, 0, 6, 31, 24, 8'h3C, 0, 0);               // R5 top byte
      5: set_req(2, 0, 0, 0, 6, 31, 16, 0, 0, 1);                   // R4 upper half
      6: set_req(2, 0, 0, 0, 7, 4, 9, 0, 0, 0);                     // R11 empty read
      7: set_req(3, 0, 0, 0, 7, 2, 6, 8'hFF, 0, 0);                 // R11 empty write
      8: set_req(2, 0, 0, 0, 9, 31, 0, 0, 0, 0);                    // R4 wide field keeps 16
      9: set_req(3, 0, 0, 0, 9, 20, 3, 8'h5A, 0, 0);                // R5 field wider than imm
      10: set_req(0, 16'h0000, -8, 0, 0, 0, 0, 0, 0, 1);            // R1 wrap-around
      default: set_req($urandom % 4, $urandom % 65536, $urandom % 1024, $urandom % 65536,
                       $urandom % 16, $urandom % 32, $urandom % 32, $urandom % 256,
                       $urandom % 2048, $urandom % 4);
    endcase
  endtask

  initial begin
    #(CLK_P * MAXC);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int issued = 0;
    bit acc = 0;
    int cyc = 0;
    logic s_req, s_we, s_space, s_gnt;
    logic [10:0] s_addr;
    logic [31:0] s_wdata;
    string atag, wtag, rtag;

    for (int i = 0; i < 2048; i++) mem[i] = 32'(i) * 32'h9E3779B9;
    for (int i = 0; i < 256; i++) regs[i] = 32'(i) * 32'h6D2B79F5 ^ 32'hC3A5_0F1E;
    bus_rdata = '0; bus_gnt = 0; rsp_ready = 0; req_valid = 0;
    set_req(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    repeat (3) begin
      @(negedge clk); #1;
      chk("R10", "req_ready", 32'(req_ready), 32'd1);
      chk("R10", "bus_req", 32'(bus_req), 32'd0);
      chk("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R10", "done", 32'(done), 32'd0);
    end
    rst_n = 1;

    while (!(issued >= NOPS && ph == 0 && !req_valid)) begin
      @(negedge clk);
      cyc++;
      if (acc) begin req_valid = 0; issued++; acc = 0; end
      if (!req_valid && issued < NOPS && ($urandom % 4) != 0) begin
        gen_op(issued);
        req_valid = 1;
      end
      bus_gnt   = ((cyc % 41) < 7) ? 1'b0 : (($urandom % 3) != 0);
      rsp_ready = ($urandom % 4) != 0;
      #1;

      atag = (m_op < 2) ? "R1" : ((m_op == 2) ? "R4" : "R5");
      wtag = (m_op == 1) ? "R2" : ((m_hi < m_lo) ? "R11" : "R5");
      rtag = (m_op == 0) ? "R3" : ((m_hi < m_lo) ? "R11" : "R4");
      chk("R7", "req_ready", 32'(req_ready), 32'(ph == 0));
      chk("R6", "bus_req", 32'(bus_req), 32'(ph == 1 || ph == 4));
      chk("R6", "bus_we", 32'(bus_we), 32'(ph == 4));
      chk("R6", "bus_space", 32'(bus_space), 32'((ph == 1 || ph == 4) && m_op >= 2));
      chk(atag, "bus_addr", 32'(bus_addr), (ph == 1 || ph == 4) ? m_addr : 32'd0);
      chk(wtag, "bus_wdata", bus_wdata, (ph == 4) ? m_wdata : 32'd0);
      chk("R8", "rsp_valid", 32'(rsp_valid), 32'(ph == 3));
      chk(rtag, "rsp_data", 32'(rsp_data), (ph == 3) ? 32'(m_rsp) : 32'd0);
      chk(rtag, "rsp_dst", 32'(rsp_dst), (ph == 3) ? 32'(m_dst) : 32'd0);
      chk("R9", "done", 32'(done), 32'((ph == 3 && rsp_ready) || (ph == 4 && bus_gnt)));

      s_req = bus_req; s_we = bus_we; s_space = bus_space; s_gnt = bus_gnt;
      s_addr = bus_addr; s_wdata = bus_wdata;

      @(posedge clk);
      case (ph)
        0: if (req_valid) begin
             acc = 1;
             m_op = int'(req_op); m_hi = int'(req_hi); m_lo = int'(req_lo); m_imm = req_imm;
             m_dst = (req_op == 2'd0) ? req_dst : 2'd0;
             if (m_op >= 2) m_addr = 32'(req_raddr);
             else           m_addr = word_of(req_base, req_off);
             if (m_op == 1) begin
               m_wdata = {16'(32'(req_pc) * 32), req_src};
               ph = 4;
             end else ph = 1;
           end
        1: if (bus_gnt) begin
             m_word = (m_op >= 2) ? regs[m_addr[7:0]] : mem[m_addr[10:0]];
             ph = 2;
           end
        2: if (m_op == 3) begin
             m_wdata = field_put(m_word, m_hi, m_lo, m_imm);
             ph = 4;
           end else begin
             m_rsp = (m_op == 0) ? m_word[15:0] : field_get(m_word, m_hi, m_lo);
             ph = 3;
           end
        3: if (rsp_ready) ph = 0;
        4: if (bus_gnt) ph = 0;
        default: ph = 0;
      endcase

      if (s_req && s_gnt) begin
        if (s_we) begin
          if (s_space) regs[s_addr[7:0]] = s_wdata;
          else         mem[s_addr] = s_wdata;
        end else begin
          bus_rdata <= s_space ? regs[s_addr[7:0]] : mem[s_addr];
        end
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule